// File: doc/BRIEF.md
# Serial Command and Diagnosis Port for an Eight-Channel Output Driver

This block is the serial slave that a host controller uses to set the eight output enables of a low-side driver and to read back its fault status. The host pulls the select line low, runs the serial clock and exchanges one or more bytes. It then releases the select line. Command bits enter on the data input and are sampled when the serial clock falls. Status bits leave on the data output, which changes when the serial clock rises. Both streams run most significant bit first.

The first bit sent is bit 15 of the 16-bit shift register. When the select line falls, the register is loaded with a snapshot of sixteen sticky fault flags. When the select line rises, the register contents move into the control word, but only if the number of serial clock falls seen during the access is a nonzero multiple of eight. In either case the fault flags are cleared at that rise. Each bit shifted in leaves the data output sixteen clocks later, so several devices can be chained.

All serial pins are synchronised into one fast system clock, and their edges are found there. The whole block therefore runs in a single clock domain.

Top module: `drv_serial_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ctrl_word` holds the default value CTRL_INIT (all zeros by default), `drive_en` is all zeros, `sdo_en` is low and every fault flag is clear.
- R2: The bit on `sdi` is shifted into bit 0 of the shift register on each falling `sck` edge during an access. `sdo` takes the new bit 15 of the register on each rising `sck` edge, so data goes out most significant bit first.
- R3: While `cs_n` is high, activity on `sck` and `sdi` has no effect on the shift register or on `ctrl_word`, and `sdo_en` is low. `sdo_en` is high during an access.
- R4: On the falling edge of `cs_n`, the shift register loads the 16 fault flags. Flag 15 appears on `sdo` before the first `sck` edge.
- R5: On the rising edge of `cs_n`, `ctrl_word` takes the 16-bit shift register value if the count of falling `sck` edges in that access is a nonzero multiple of 8. Otherwise (zero edges, or a count such as 7, 9 or 13) `ctrl_word` is unchanged.
- R6: Each fault flag is set by a one-cycle high on its `diag_set` bit and stays set until the next rising edge of `cs_n`, which clears all flags. A set arriving in the same cycle as the clear wins. The clear happens whether or not the frame is committed.
- R7: For a frame longer than 16 bits, the bit shifted in on falling edge k appears on `sdo` after rising edge k+16.
- R8: `drive_en[i]` equals `ctrl_word[i]` for channels 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for the `sdo` pad; the pad is high impedance when low |
| diag_set | input | 16 | One-cycle fault set pulses from the sensing logic |
| ctrl_word | output | 16 | Committed control register |
| drive_en | output | 8 | Output enables for the eight channels |

## Verification
A pin change becomes visible in the clock domain after two synchroniser flops and one edge-history flop. The register it acts on updates one cycle later. So `sdo`, `sdo_en`, the shift register and `ctrl_word` react three to four system cycles after an edge on `cs_n` or `sck`. The bench holds each serial phase for eight system cycles and samples `sdo` at the end of the high phase of `sck`, just before the next falling edge. It reads `ctrl_word`, `drive_en` and `sdo_en` eight cycles after `cs_n` rises. Every sample therefore lands after the latency has passed and before the next pin change.

// File: rtl/drv_serial_pkg.sv
package drv_serial_pkg;

    typedef struct packed {
        logic fall;
        logic rise;
    } edge_t;

    function automatic edge_t detect_edge(input logic now_v, input logic prev_v);
        edge_t e;
        e.fall = prev_v & ~now_v;
        e.rise = ~prev_v & now_v;
        return e;
    endfunction

endpackage

// File: rtl/drv_serial_sync.sv
module drv_serial_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = async_in;
        s_d.stab = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.meta <= RST_VAL;
            s_q.stab <= RST_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_out = s_q.stab;

endmodule

// File: rtl/drv_serial_shifter.sv
module drv_serial_shifter #(
    parameter int SR_W      = 16,
    parameter int UNIT_LOG2 = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            active,
    input  logic            sck_fall,
    input  logic            sck_rise,
    input  logic            sdi_s,
    input  logic [SR_W-1:0] load_val,
    output logic [SR_W-1:0] sr_out,
    output logic            sdo_bit,
    output logic            frame_ok
);

    localparam int CNT_W = (UNIT_LOG2 < 1) ? 1 : UNIT_LOG2;

    typedef struct packed {
        logic [SR_W-1:0]  sr;
        logic             sdo;
        logic [CNT_W-1:0] cnt;
        logic             seen;
    } shf_t;

    shf_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (load) begin
            f_d.sr   = load_val;
            f_d.sdo  = load_val[SR_W-1];
            f_d.cnt  = '0;
            f_d.seen = 1'b0;
        end else if (active) begin
            if (sck_fall) begin
                f_d.sr   = {f_q.sr[SR_W-2:0], sdi_s};
                f_d.cnt  = f_q.cnt + 1'b1;
                f_d.seen = 1'b1;
            end
            if (sck_rise) begin
                f_d.sdo = f_q.sr[SR_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign sr_out   = f_q.sr;
    assign sdo_bit  = f_q.sdo;
    assign frame_ok = f_q.seen && (f_q.cnt == '0);

endmodule

// File: rtl/drv_serial_diag.sv
module drv_serial_diag #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] flags
);

    typedef struct packed {
        logic [W-1:0] flag;
    } dg_t;

    dg_t g_d, g_q;

    always_comb begin
        g_d      = g_q;
        g_d.flag = (clr_i ? '0 : g_q.flag) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign flags = g_q.flag;

endmodule

// File: rtl/drv_serial_ctrl.sv
module drv_serial_ctrl #(
    parameter int NCH       = 8,
    parameter int SR_W      = 2 * NCH,
    parameter int UNIT_LOG2 = 3,
    parameter logic [SR_W-1:0] CTRL_INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            sdi,
    output logic            sdo,
    output logic            sdo_en,
    input  logic [SR_W-1:0] diag_set,
    output logic [SR_W-1:0] ctrl_word,
    output logic [NCH-1:0]  drive_en
);

    import drv_serial_pkg::*;

    logic [2:0]      pins_s;
    logic            cs_s, sck_s, sdi_s;
    edge_t           cs_e, sck_e;
    logic            cs_fall, cs_rise, active;
    logic [SR_W-1:0] sr_q;
    logic [SR_W-1:0] diag_q;
    logic            frame_ok;
    logic            sdo_bit;

    typedef struct packed {
        logic            cs_prev;
        logic            sck_prev;
        logic [SR_W-1:0] ctrl;
    } top_t;

    top_t t_d, t_q;

    drv_serial_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({cs_n, sck, sdi}),
        .sync_out(pins_s)
    );

    assign cs_s  = pins_s[2];
    assign sck_s = pins_s[1];
    assign sdi_s = pins_s[0];

    assign cs_e    = detect_edge(cs_s, t_q.cs_prev);
    assign sck_e   = detect_edge(sck_s, t_q.sck_prev);
    assign cs_fall = cs_e.fall;
    assign cs_rise = cs_e.rise;
    assign active  = ~cs_s & ~t_q.cs_prev;

    drv_serial_shifter #(.SR_W(SR_W), .UNIT_LOG2(UNIT_LOG2)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cs_fall),
        .active  (active),
        .sck_fall(sck_e.fall),
        .sck_rise(sck_e.rise),
        .sdi_s   (sdi_s),
        .load_val(diag_q),
        .sr_out  (sr_q),
        .sdo_bit (sdo_bit),
        .frame_ok(frame_ok)
    );

    drv_serial_diag #(.W(SR_W)) u_diag (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(diag_set),
        .clr_i(cs_rise),
        .flags(diag_q)
    );

    always_comb begin
        t_d          = t_q;
        t_d.cs_prev  = cs_s;
        t_d.sck_prev = sck_s;
        if (cs_rise && frame_ok) begin
            t_d.ctrl = sr_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cs_prev  <= 1'b1;
            t_q.sck_prev <= 1'b0;
            t_q.ctrl     <= CTRL_INIT;
        end else begin
            t_q <= t_d;
        end
    end

    assign sdo       = sdo_bit;
    assign sdo_en    = ~t_q.cs_prev;
    assign ctrl_word = t_q.ctrl;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_drv
            assign drive_en[c] = t_q.ctrl[c];
        end
    endgenerate

endmodule

// File: rtl/drv_serial_ctrl_chk.sv
module drv_serial_ctrl_chk #(
    parameter int SR_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_fall,
    input logic            cs_rise,
    input logic            active,
    input logic            frame_ok,
    input logic [SR_W-1:0] diag_set,
    input logic [SR_W-1:0] diag_q,
    input logic [SR_W-1:0] sr_q,
    input logic [SR_W-1:0] ctrl_word
);

    assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_rise && frame_ok) |=> $stable(ctrl_word));

    assert_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && frame_ok) |=> (ctrl_word == $past(sr_q)));

    assert_diag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && (diag_set == '0)) |=> (diag_q == '0));

    assert_diag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> ((diag_q & $past(diag_q)) == $past(diag_q)));

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (sr_q == $past(diag_q)));

    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !cs_fall) |=> $stable(sr_q));

endmodule

bind drv_serial_ctrl drv_serial_ctrl_chk #(.SR_W(SR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .active   (active),
    .frame_ok (frame_ok),
    .diag_set (diag_set),
    .diag_q   (diag_q),
    .sr_q     (sr_q),
    .ctrl_word(ctrl_word)
);

// File: tb/drv_serial_ctrl_bench.sv
module drv_serial_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, sck, sdi;
    logic        sdo, sdo_en;
    logic [15:0] diag_set;
    logic [15:0] ctrl_word;
    logic [7:0]  drive_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] diag_m;
    logic [15:0] ctrl_m;

    always #10 clk = ~clk;

    drv_serial_ctrl u_drv_serial_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .sdi      (sdi),
        .sdo      (sdo),
        .sdo_en   (sdo_en),
        .diag_set (diag_set),
        .ctrl_word(ctrl_word),
        .drive_en (drive_en)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_set(input logic [15:0] v);
        @(negedge clk) diag_set = v;
        @(negedge clk) diag_set = '0;
        diag_m |= v;
    endtask

    task automatic frame(input int nb, input logic [63:0] data);
        logic [15:0] sr;
        sr = diag_m;
        @(negedge clk) cs_n = 1'b0;
        waitc(8);
        chk(sdo_en === 1'b1, "R3 sdo_en in access", 32'(sdo_en), 32'd1);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk) begin sck = 1'b1; sdi = data[nb-1-i]; end
            waitc(8);
            chk(sdo === sr[15], (i == 0) ? "R4 first sdo bit" : ((i >= 16) ? "R7 chained sdo bit" : "R2 sdo bit"),
                32'(sdo), 32'(sr[15]));
            @(negedge clk) sck = 1'b0;
            waitc(8);
            sr = {sr[14:0], data[nb-1-i]};
        end
        @(negedge clk) cs_n = 1'b1;
        waitc(8);
        if (nb > 0 && (nb % 8) == 0) ctrl_m = sr;
        diag_m = '0;
        chk(ctrl_word === ctrl_m, "R5 ctrl_word after frame", 32'(ctrl_word), 32'(ctrl_m));
        chk(drive_en === ctrl_m[7:0], "R8 drive_en", 32'(drive_en), 32'(ctrl_m[7:0]));
        chk(sdo_en === 1'b0, "R3 sdo_en idle", 32'(sdo_en), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; diag_set = '0;
        diag_m = '0; ctrl_m = '0;
        waitc(5);
        chk(ctrl_word === 16'h0, "R1 ctrl_word in reset", 32'(ctrl_word), 32'd0);
        chk(drive_en === 8'h0, "R1 drive_en in reset", 32'(drive_en), 32'd0);
        chk(sdo_en === 1'b0, "R1 sdo_en in reset", 32'(sdo_en), 32'd0);
        rst_n = 1'b1;
        waitc(4);

        // R5 R6: sweep of frame lengths with fresh fault patterns each time
        for (int nb = 0; nb <= 40; nb++) begin
            pulse_set(16'((nb + 1) * 4951));
            pulse_set(16'h8001 << (nb % 8));
            frame(nb, 64'hC3A596E10F5A7B2D ^ (64'(nb) * 64'h9E3779B97F4A7C15));
        end

        // R3: pin activity with select high must be ignored
        for (int k = 0; k < 20; k++) begin
            @(negedge clk) begin sck = ~sck; sdi = k[0]; end
            waitc(6);
            chk(sdo_en === 1'b0, "R3 sdo_en while deselected", 32'(sdo_en), 32'd0);
        end
        @(negedge clk) begin sck = 1'b0; sdi = 1'b0; end
        waitc(8);
        chk(ctrl_word === ctrl_m, "R3 ctrl_word untouched", 32'(ctrl_word), 32'(ctrl_m));
        pulse_set(16'h5AA5);
        frame(16, 64'h0000_0000_0000_3CC3);

        // R6: a frame with a bad length still clears the flags
        pulse_set(16'hF00F);
        frame(5, 64'h15);
        frame(16, 64'h0000_0000_0000_0F0F);

        // R1: reset returns the control word to its default
        frame(8, 64'hFF);
        @(negedge clk) rst_n = 1'b0;
        waitc(3);
        ctrl_m = '0;
        diag_m = '0;
        chk(ctrl_word === 16'h0, "R1 ctrl_word after reset", 32'(ctrl_word), 32'd0);
        chk(drive_en === 8'h0, "R1 drive_en after reset", 32'(drive_en), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        waitc(4);
        frame(24, 64'h00A1_B2C3);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule